// File: doc/BRIEF.md
# Maskable Interrupt Pin Controller

This block gathers eight event sources into a single interrupt request pin. Each event input carries a one-cycle pulse. The pulse sets a sticky status bit, and that bit stays set until software reads it. A per-bit enable mask decides which pending bits may raise the pin. A programmable level bit selects the pin's asserted polarity. When no enabled bit is pending, the output enable drops and the pad floats instead of driving an inactive level.

Software reaches the block through a simple register bus with read and write strobes, an address and 16-bit data. The bus is the kind a serial management slave would drive. Two registers are mapped. The interrupt register holds the status bits in its low byte and the enable bits in its high byte, and a read of it clears the status. The control register holds the level bit at bit 14. Read data is combinational from the address, so a peek without the read strobe shows the contents without clearing anything.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset, every status bit, every enable bit and the level bit are zero, the interrupt and control registers read 0x0000, and `irq_oe` is low.
- R2: A one-cycle pulse on `evt_pulse[i]` sets status bit i, which is visible at bit i of the interrupt register (address 17) after the next clock edge. The bit stays set, with no further pulses, until a read strobe to that register.
- R3: A read strobe to the interrupt register returns the enable bits in [15:8] and the status bits in [7:0] during the strobe cycle. From the next cycle, all status bits not re-triggered in that cycle read zero.
- R4: An event pulse that arrives in the same cycle as a clearing read is kept: its status bit reads one after the read.
- R5: A write to the interrupt register loads the enable bits from data bits [15:8]. Data bits [7:0] of such a write have no effect on the status bits.
- R6: With the default unregistered output, `irq_oe` is high exactly when some status bit and its enable bit are both set, starting in the cycle after the setting edge. It falls in the cycle after the clearing read.
- R7: Bit 14 of the control register (address 16) is read/write and sets the pin level: `irq_out` equals this bit, so 1 means active high and 0 means active low. The other bits of the control register read zero.
- R8: Reads of any unmapped address return 0xFFFF, and writes to unmapped addresses change no register.
- R9: A status bit whose enable is zero still latches and reads back, but it does not raise `irq_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pulse | input | 8 | One-cycle event pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the interrupt register clears its status |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| irq_out | output | 1 | Value the pad drives while enabled (the active level) |
| irq_oe | output | 1 | Pad output enable; low means the pin floats |

## Verification
An event pulse or a register write takes effect at one clock edge, so its status, enable or level value is due on the read data in the first cycle after that edge. The default output enable follows on the same cycle. Read data is due in the strobe cycle itself. The bench changes inputs at the falling edge, samples read data 1 ns later, and samples state and pin values at the falling edge after the effective rising edge. A peek with no strobe shows state without disturbing it, which lets the "stays set" and "has no effect" cases be observed between stimuli.

// File: rtl/irq_pin_pkg.sv
package irq_pin_pkg;
   localparam int unsigned WORD_W = 16;
   typedef logic [WORD_W-1:0] word_t;
   localparam word_t UNMAPPED_VAL = '1;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
   parameter int unsigned N_EVT = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             clr_i,
   output logic [N_EVT-1:0] stat_o
);
   // one sticky flop per source; a new event beats a simultaneous clear
   for (genvar g = 0; g < N_EVT; g++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q <= 1'b0;
         else if (evt_i[g])   flag_q <= 1'b1;
         else if (clr_i)      flag_q <= 1'b0;
      end
      assign stat_o[g] = flag_q;
   end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
   import irq_pin_pkg::*;
#(
   parameter int unsigned N_EVT     = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned IRQ_ADDR  = 17,
   parameter int unsigned CTRL_ADDR = 16,
   parameter int unsigned LEVEL_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  word_t             wdata_i,
   input  logic [N_EVT-1:0]  stat_i,
   output word_t             rdata_o,
   output logic [N_EVT-1:0]  en_o,
   output logic              level_o,
   output logic              clr_o
);
   localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(IRQ_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   logic hit_irq, hit_ctrl;
   logic [N_EVT-1:0] en_q;
   logic level_q;

   assign hit_irq  = (addr_i == A_IRQ);
   assign hit_ctrl = (addr_i == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         level_q <= 1'b0;
      end else if (wr_i) begin
         if (hit_irq)  en_q    <= wdata_i[2*N_EVT-1:N_EVT];
         if (hit_ctrl) level_q <= wdata_i[LEVEL_BIT];
      end
   end

   always_comb begin
      rdata_o = UNMAPPED_VAL;
      if (hit_irq) begin
         rdata_o = '0;
         rdata_o[N_EVT-1:0]       = stat_i;
         rdata_o[2*N_EVT-1:N_EVT] = en_q;
      end else if (hit_ctrl) begin
         rdata_o = '0;
         rdata_o[LEVEL_BIT] = level_q;
      end
   end

   assign clr_o   = rd_i && hit_irq;
   assign en_o    = en_q;
   assign level_o = level_q;
endmodule

// File: rtl/irq_pin_out.sv
module irq_pin_out #(
   parameter int unsigned N_EVT   = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] stat_i,
   input  logic [N_EVT-1:0] en_i,
   input  logic             level_i,
   output logic             oe_o,
   output logic             pin_o
);
   logic pend;
   assign pend  = |(stat_i & en_i);
   assign pin_o = level_i;

   if (REG_OUT) begin : g_reg
      logic oe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) oe_q <= 1'b0;
         else        oe_q <= pend;
      end
      assign oe_o = oe_q;
   end else begin : g_comb
      assign oe_o = pend;
   end
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
   import irq_pin_pkg::*;
#(
   parameter int unsigned N_EVT     = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned IRQ_ADDR  = 17,
   parameter int unsigned CTRL_ADDR = 16,
   parameter int unsigned LEVEL_BIT = 14,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              irq_out,
   output logic              irq_oe
);
   initial begin
      if (2*N_EVT > WORD_W) $error("irq_pin_ctrl: status and enable do not fit one word");
      if (LEVEL_BIT >= WORD_W) $error("irq_pin_ctrl: level bit outside word");
      if (IRQ_ADDR == CTRL_ADDR) $error("irq_pin_ctrl: register addresses collide");
      if (IRQ_ADDR >= (1 << ADDR_W) || CTRL_ADDR >= (1 << ADDR_W))
         $error("irq_pin_ctrl: address exceeds ADDR_W");
   end

   logic [N_EVT-1:0] stat_w, en_w;
   logic level_w, clr_w;

   irq_evt_latch #(.N_EVT(N_EVT)) latch_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .clr_i(clr_w), .stat_o(stat_w)
   );

   irq_reg_file #(
      .N_EVT(N_EVT), .ADDR_W(ADDR_W), .IRQ_ADDR(IRQ_ADDR),
      .CTRL_ADDR(CTRL_ADDR), .LEVEL_BIT(LEVEL_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .stat_i(stat_w), .rdata_o(reg_rdata), .en_o(en_w),
      .level_o(level_w), .clr_o(clr_w)
   );

   irq_pin_out #(.N_EVT(N_EVT), .REG_OUT(REG_OUT)) pin_i (
      .clk(clk), .rst_n(rst_n), .stat_i(stat_w), .en_i(en_w), .level_i(level_w),
      .oe_o(irq_oe), .pin_o(irq_out)
   );
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
   parameter int unsigned N_EVT     = 8,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned IRQ_ADDR  = 17,
   parameter int unsigned CTRL_ADDR = 16,
   parameter int unsigned LEVEL_BIT = 14,
   parameter bit          REG_OUT   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  evt_pulse,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [15:0]       reg_wdata,
   input logic              irq_out,
   input logic              irq_oe,
   input logic [N_EVT-1:0]  stat,
   input logic [N_EVT-1:0]  en
);
   localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(IRQ_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   // R2: without a clearing read, status only gains the pulsed bits
   a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == A_IRQ) |=> stat == ($past(stat) | $past(evt_pulse)));

   // R3 and R4: after a clearing read only the simultaneous events remain
   a_r4_evt_survives: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_IRQ) |=> stat == $past(evt_pulse));

   // R5: interrupt register write loads the enables from the high byte
   a_r5_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_IRQ) |=> en == $past(reg_wdata[2*N_EVT-1:N_EVT]));

   // R7: control write sets the pin level
   a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CTRL) |=> irq_out == $past(reg_wdata[LEVEL_BIT]));

   // R6 and R9: pin enable tracks masked pending state
   if (REG_OUT) begin : g_reg
      a_r6_oe_track: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> irq_oe == $past(|(stat & en)));
   end else begin : g_comb
      a_r6_oe_track: assert property (@(posedge clk) disable iff (!rst_n)
         irq_oe == |(stat & en));
   end
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(
   .N_EVT(N_EVT), .ADDR_W(ADDR_W), .IRQ_ADDR(IRQ_ADDR),
   .CTRL_ADDR(CTRL_ADDR), .LEVEL_BIT(LEVEL_BIT), .REG_OUT(REG_OUT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_out(irq_out), .irq_oe(irq_oe),
   .stat(stat_w), .en(en_w)
);

// File: tb/irq_pin_ctrl_tb_top.sv
module irq_pin_ctrl_tb_top;
   localparam logic [4:0] A_IRQ  = 5'd17;
   localparam logic [4:0] A_CTRL = 5'd16;
   localparam logic [4:0] A_NONE = 5'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] evt_pulse = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [4:0] reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic irq_out, irq_oe;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_pin_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_out(irq_out), .irq_oe(irq_oe)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic peek(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic bus_read(input logic [4:0] a, input logic [7:0] ev, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1; evt_pulse = ev;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0; evt_pulse = '0;
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [15:0] v);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      evt_pulse = m;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      peek(A_IRQ, d);  chk(d == 16'h0000, "R1", d, 16'h0000);
      peek(A_CTRL, d); chk(d == 16'h0000, "R1", d, 16'h0000);
      chk(irq_oe == 1'b0, "R1", {15'd0, irq_oe}, 16'h0000);
   endtask

   task automatic t_single_event;
      logic [15:0] d;
      pulse(8'h05);
      peek(A_IRQ, d); chk(d == 16'h0005, "R2", d, 16'h0005);
      chk(irq_oe == 1'b0, "R9", {15'd0, irq_oe}, 16'h0000);
      repeat (5) @(negedge clk);
      peek(A_IRQ, d); chk(d == 16'h0005, "R2", d, 16'h0005);
   endtask

   task automatic t_clear_on_read;
      logic [15:0] d;
      bus_read(A_IRQ, 8'h00, d); chk(d == 16'h0005, "R3", d, 16'h0005);
      peek(A_IRQ, d);            chk(d == 16'h0000, "R3", d, 16'h0000);
   endtask

   task automatic t_collision;
      logic [15:0] d;
      pulse(8'h01);
      bus_read(A_IRQ, 8'h80, d); chk(d == 16'h0001, "R4", d, 16'h0001);
      peek(A_IRQ, d);            chk(d == 16'h0080, "R4", d, 16'h0080);
      bus_read(A_IRQ, 8'h00, d); chk(d == 16'h0080, "R3", d, 16'h0080);
   endtask

   task automatic t_enable_write;
      logic [15:0] d;
      bus_write(A_IRQ, 16'h3CFF);
      peek(A_IRQ, d); chk(d == 16'h3C00, "R5", d, 16'h3C00);
      chk(irq_oe == 1'b0, "R5", {15'd0, irq_oe}, 16'h0000);
   endtask

   task automatic t_mask;
      logic [15:0] d;
      pulse(8'h01);
      chk(irq_oe == 1'b0, "R9", {15'd0, irq_oe}, 16'h0000);
      peek(A_IRQ, d); chk(d == 16'h3C01, "R9", d, 16'h3C01);
      pulse(8'h04);
      chk(irq_oe == 1'b1, "R6", {15'd0, irq_oe}, 16'h0001);
      bus_read(A_IRQ, 8'h00, d); chk(d == 16'h3C05, "R3", d, 16'h3C05);
      chk(irq_oe == 1'b0, "R6", {15'd0, irq_oe}, 16'h0000);
   endtask

   task automatic t_polarity;
      logic [15:0] d;
      chk(irq_out == 1'b0, "R7", {15'd0, irq_out}, 16'h0000);
      bus_write(A_CTRL, 16'hFFFF);
      peek(A_CTRL, d); chk(d == 16'h4000, "R7", d, 16'h4000);
      chk(irq_out == 1'b1, "R7", {15'd0, irq_out}, 16'h0001);
      bus_write(A_CTRL, 16'h0000);
      chk(irq_out == 1'b0, "R7", {15'd0, irq_out}, 16'h0000);
   endtask

   task automatic t_unmapped;
      logic [15:0] d;
      bus_write(A_NONE, 16'hFFFF);
      peek(A_NONE, d); chk(d == 16'hFFFF, "R8", d, 16'hFFFF);
      peek(A_IRQ, d);  chk(d == 16'h3C00, "R8", d, 16'h3C00);
      peek(A_CTRL, d); chk(d == 16'h0000, "R8", d, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single_event();
      t_clear_on_read();
      t_collision();
      t_enable_write();
      t_mask();
      t_polarity();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule